// File: doc/BRIEF.md
# Shift-Rotate Unit with Flags

This block transforms one byte-wide operand per transaction by one of six shift-type operations: logical shift left or right, rotate left or right through the carry, arithmetic shift right, and nibble swap. Alongside the result it produces the zero, carry, negative, overflow and half-carry flag values. It also produces a write-enable mask that names the flags the selected operation is allowed to change, so a surrounding status register can merge the new values and leave the others alone. The register file and the status storage live outside the block.

Operands arrive on a valid/ready input stream together with the incoming carry and a 3-bit operation code. The transformation itself is combinational, and its outcome is captured in a single output register that drives a valid/ready output stream. A transfer happens on a rising edge where valid and ready are both high. The input may be taken whenever the output register is empty or is being emptied in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` is low and the pending result is held unchanged. With `out_ready` held high the unit accepts one operand per cycle.

Top module: `sru_shift_unit`

## Requirements
- R1: Operation code 0 (shift left) moves every bit up one place and puts 0 into bit 0. The old bit 7 becomes the new carry.
- R2: Operation code 1 (shift right) moves every bit down one place and puts 0 into bit 7. The old bit 0 becomes the new carry.
- R3: Operation code 2 (rotate left) puts the incoming carry into bit 0 and moves the other bits up. The old bit 7 becomes the new carry.
- R4: Operation code 3 (rotate right) puts the incoming carry into bit 7 and moves the other bits down. The old bit 0 becomes the new carry.
- R5: Operation code 4 (arithmetic shift right) copies bits 7..1 into bits 6..0 and keeps bit 7. The old bit 0 becomes the new carry.
- R6: Operation code 5 (nibble swap) exchanges the upper and lower 4-bit halves, changes no flag, and returns a mask and flag vector of all zeros.
- R7: Operation codes 6 and 7 are reserved. They return the operand unchanged, with a mask and flag vector of all zeros.
- R8: The flag and mask vectors use bit 0 for C, bit 1 for Z, bit 2 for N, bit 3 for V and bit 4 for H. Codes 0 and 2 give mask 5'b11111. Codes 1, 3 and 4 give mask 5'b01111. A flag bit outside the mask always reads 0.
- R9: When enabled, Z is 1 exactly when the result is zero, N equals result bit 7, and V equals N XOR the new C.
- R10: For codes 0 and 2, H equals bit 3 of the operand.
- R11: A result is presented with `out_valid` high in the cycle after its operand is accepted. Results come out in the order their operands were accepted.
- R12: `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output contents stay unchanged.
- R13: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_data | input | 8 | Operand |
| in_carry | input | 1 | Incoming carry flag |
| in_op | input | 3 | Operation code |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 8 | Result byte |
| out_flags | output | 5 | New flag values (C, Z, N, V, H from bit 0 up) |
| out_mask | output | 5 | Flags that the operation updates, same bit order |

## Verification
The hardest condition to reach from the ports is a stalled output register while a fresh operand is already waiting on the input. In that state `in_ready` must fall, and neither the held result nor the waiting operand may be lost or duplicated. The stimulus creates this state with a directed stall of several cycles while `in_valid` stays high. It then sweeps every operand, carry and operation code with randomly timed input gaps and randomly timed back-pressure. A queue-based model compares the output against the oldest expected result on every cycle that `out_valid` is high, so any change to a held result during a stall shows up as a mismatch.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_RCL  = 3'd2,
    OP_RCR  = 3'd3,
    OP_SAR  = 3'd4,
    OP_NSWP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sru_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_N   = 2;
  localparam int FL_V   = 3;
  localparam int FL_H   = 4;

  typedef logic [FLAG_W-1:0] sru_flags_t;

  localparam sru_flags_t MASK_LEFT  = 5'b11111;
  localparam sru_flags_t MASK_RIGHT = 5'b01111;
  localparam sru_flags_t MASK_NONE  = 5'b00000;

endpackage

// File: rtl/sru_shifter.sv
module sru_shifter
  import sru_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd,
  input  logic         cin,
  input  sru_op_e      op,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         half_bit
);
  localparam int HALF = W / 2;

  logic [W-1:0] swapped;

  // half swap built lane by lane
  for (genvar i = 0; i < HALF; i++) begin : g_swap
    assign swapped[i]        = opnd[i + HALF];
    assign swapped[i + HALF] = opnd[i];
  end

  assign half_bit = opnd[HALF-1];

  always_comb begin
    res  = opnd;
    cout = cin;
    unique case (op)
      OP_SHL: begin
        res  = {opnd[W-2:0], 1'b0};
        cout = opnd[W-1];
      end
      OP_SHR: begin
        res  = {1'b0, opnd[W-1:1]};
        cout = opnd[0];
      end
      OP_RCL: begin
        res  = {opnd[W-2:0], cin};
        cout = opnd[W-1];
      end
      OP_RCR: begin
        res  = {cin, opnd[W-1:1]};
        cout = opnd[0];
      end
      OP_SAR: begin
        res  = {opnd[W-1], opnd[W-1:1]};
        cout = opnd[0];
      end
      OP_NSWP: begin
        res  = swapped;
        cout = cin;
      end
      default: begin
        res  = opnd;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
  import sru_pkg::*;
#(
  parameter int W = 8
) (
  input  sru_op_e      op,
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         half_bit,
  output sru_flags_t   flags,
  output sru_flags_t   mask
);
  sru_flags_t raw;

  always_comb begin
    unique case (op)
      OP_SHL, OP_RCL:         mask = MASK_LEFT;
      OP_SHR, OP_RCR, OP_SAR: mask = MASK_RIGHT;
      default:                mask = MASK_NONE;
    endcase
  end

  always_comb begin
    raw       = '0;
    raw[FL_C] = cout;
    raw[FL_Z] = (res == '0);
    raw[FL_N] = res[W-1];
    raw[FL_V] = res[W-1] ^ cout;
    raw[FL_H] = half_bit;
  end

  assign flags = raw & mask;
endmodule

// File: rtl/sru_out_stage.sv
module sru_out_stage #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [PW-1:0] s_payload,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [PW-1:0] m_payload
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid   <= 1'b0;
      m_payload <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_payload <= s_payload;
    end
  end
endmodule

// File: rtl/sru_shift_unit.sv
module sru_shift_unit
  import sru_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [W-1:0]        in_data,
  input  logic                in_carry,
  input  logic [2:0]          in_op,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic [FLAG_W-1:0]   out_flags,
  output logic [FLAG_W-1:0]   out_mask
);
  localparam int PW = W + 2 * FLAG_W;

  sru_op_e      op;
  logic [W-1:0] res;
  logic         cout;
  logic         half_bit;
  sru_flags_t   flags;
  sru_flags_t   mask;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  assign op = sru_op_e'(in_op);

  sru_shifter #(.W(W)) u_shift (
    .opnd     (in_data),
    .cin      (in_carry),
    .op       (op),
    .res      (res),
    .cout     (cout),
    .half_bit (half_bit)
  );

  sru_flag_gen #(.W(W)) u_flags (
    .op       (op),
    .res      (res),
    .cout     (cout),
    .half_bit (half_bit),
    .flags    (flags),
    .mask     (mask)
  );

  assign pay_in = {res, flags, mask};

  sru_out_stage #(.PW(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (in_valid),
    .s_ready   (in_ready),
    .s_payload (pay_in),
    .m_valid   (out_valid),
    .m_ready   (out_ready),
    .m_payload (pay_out)
  );

  assign out_data  = pay_out[PW-1 -: W];
  assign out_flags = pay_out[2*FLAG_W-1 -: FLAG_W];
  assign out_mask  = pay_out[FLAG_W-1:0];
endmodule

// File: rtl/sru_shift_unit_chk.sv
module sru_shift_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         in_carry,
  input logic [2:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic [4:0]   out_flags,
  input logic [4:0]   out_mask
);
  // R6
  swap_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'd5) |=> (out_mask == 5'b0 && out_flags == 5'b0));

  // R7
  reserved_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[2:1] == 2'b11) |=> (out_mask == 5'b0 && out_data == $past(in_data)));

  // R8
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & ~out_mask) == 5'b0));

  // R9
  overflow_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mask[3]) |-> (out_flags[3] == (out_flags[2] ^ out_flags[0])));

  // R9
  zero_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mask[1]) |-> (out_flags[1] == (out_data == '0)));

  // R11
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R12
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R12
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flags) && $stable(out_mask)));

  // R13
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind sru_shift_unit sru_shift_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_carry  (in_carry),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_flags (out_flags),
  .out_mask  (out_mask)
);

// File: tb/sru_shift_unit_test.sv
module sru_shift_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_carry = 1'b0;
  logic [2:0] in_op = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic [4:0] out_flags;
  logic [4:0] out_mask;

  int n_checks = 0;
  int n_errs = 0;

  typedef struct {
    int data;
    int flags;
    int mask;
    int op;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  sru_shift_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_carry  (in_carry),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_flags (out_flags),
    .out_mask  (out_mask)
  );

  function automatic string op_req(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Behavioural model: arithmetic on integers.
  function automatic exp_t model(int a, int cin, int op);
    exp_t e;
    int r, c, m, z, n, v, h;
    r = a;
    c = cin;
    m = 0;
    case (op)
      0: begin r = (a * 2) % 256;       c = a / 128; m = 31; end
      1: begin r = a / 2;               c = a % 2;   m = 15; end
      2: begin r = (a * 2) % 256 + cin; c = a / 128; m = 31; end
      3: begin r = a / 2 + cin * 128;   c = a % 2;   m = 15; end
      4: begin r = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; m = 15; end
      5: begin r = (a % 16) * 16 + a / 16; m = 0; end
      default: begin r = a; m = 0; end
    endcase
    z = (r == 0) ? 1 : 0;
    n = (r >= 128) ? 1 : 0;
    v = (n != c) ? 1 : 0;  // R9
    h = (a / 8) % 2;       // R10
    e.data  = r;
    e.flags = (c + 2 * z + 4 * n + 8 * v + 16 * h) & m;
    e.mask  = m;
    e.op    = op;
    return e;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(bit iv, int a, int c, int op, bit ordy);
    @(negedge clk);
    in_valid  = iv;
    in_data   = a[7:0];
    in_carry  = c[0];
    in_op     = op[2:0];
    out_ready = ordy;
    #1;
    // R12: ready rule
    check("R12", int'(in_ready), int'(!out_valid || out_ready));
    // R11: nothing waits inside while the output is empty
    if (!out_valid) check("R11", q.size(), 0);
    if (out_valid) begin
      if (q.size() == 0) begin
        check("R11", 1, 0);
      end else begin
        check(op_req(q[0].op), int'(out_data), q[0].data);
        check((q[0].op < 5) ? "R9/R10" : op_req(q[0].op), int'(out_flags), q[0].flags);
        check("R8", int'(out_mask), q[0].mask);
        if (out_ready) void'(q.pop_front());
      end
    end
    if (in_valid && in_ready) q.push_back(model(a, c, op));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13
    check("R13", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    cycle(1, 8'h80, 0, 0, 1);  // R1: result zero, C=1
    cycle(1, 8'h08, 0, 0, 1);  // R10: H from bit 3
    cycle(1, 8'h80, 1, 2, 1);  // R3
    cycle(1, 8'h01, 1, 3, 1);  // R4
    cycle(1, 8'h81, 0, 4, 1);  // R5 keeps sign
    cycle(1, 8'h01, 1, 1, 1);  // R2 zero result
    cycle(1, 8'hA5, 1, 5, 1);  // R6
    cycle(1, 8'h3C, 1, 6, 1);  // R7
    cycle(1, 8'hC3, 0, 7, 1);  // R7

    // R12: stall with a waiting operand
    cycle(1, 8'h40, 0, 0, 0);
    for (int k = 0; k < 5; k++) cycle(1, 8'h11 + k, 1, 2, 0);
    cycle(1, 8'h77, 1, 3, 1);
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1);

    // sweep with random gaps and back-pressure
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a++) begin
          bit sent;
          sent = 0;
          while (!sent) begin
            bit iv;
            iv = ($urandom_range(0, 3) != 0);
            cycle(iv, a, c, op, ($urandom_range(0, 3) != 0));
            sent = iv && in_ready;
          end
        end
      end
    end

    // drain
    for (int k = 0; k < 4; k++) cycle(0, 0, 0, 0, 1);
    check("R11", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule